// File: doc/BRIEF.md
# Video Port Access Pacer

This block sits on the write path between a CPU's I/O bus and a video display processor. The display processor accepts writes to its data port only at a limited rate. The block watches the port-write requests, counts clock cycles since the last accepted data-port write, and raises a wait signal to the CPU. The wait holds an access back until enough time has passed.

The minimum spacing between data writes depends on the display phase. The short spacing applies while the picture is blanked, during vertical blank, or in text mode. The long spacing applies in the active picture of any other mode.

A control-port write that follows a data write is also held back until the processor has had time to move the data byte into its memory. Without that hold, an early address write could redirect the byte to the wrong location.

A bypass input turns all wait generation off. All limits are given in nanoseconds and the CPU clock rate in kHz. They are turned into cycle counts at elaboration.

Top module: `vdp_pace`

## Requirements
- R1: After reset the wait output is low, and the first data write after reset is accepted without any wait cycle.
- R2: When the blank, vertical-blank or text-mode flag is high, a data write (I/O address 1) that arrives fewer than FAST_CYC cycles after the previous accepted data write is held. FAST_CYC defaults to 8 for 2000 ns at 4000 kHz.
- R3: When none of the three phase flags is high, the spacing for data writes is SLOW_CYC cycles. SLOW_CYC defaults to 32 for 8000 ns.
- R4: Wait is released on the first clock edge at which the cycle count since the last accepted data write reaches the active threshold. A request arriving later than the threshold gets no wait at all.
- R5: A control write (I/O address 2) that arrives fewer than XFER_CYC cycles after the last accepted data write is held until that count is reached. XFER_CYC defaults to 12 for 3000 ns.
- R6: Only accepted data writes restart the spacing count. Control writes and other writes leave it running.
- R7: Writes to any address other than 1 or 2 never raise wait.
- R8: While the bypass input is high, wait stays low for every access.
- R9: A write request that stays asserted after it has been accepted is counted once. It raises no further wait and does not restart the spacing count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Write request, held by the CPU until wait is low at a clock edge |
| io_addr | input | ADDR_W | I/O port address of the request |
| ph_blank | input | 1 | Picture output is blanked |
| ph_vblank | input | 1 | Display is in vertical blank |
| ph_text | input | 1 | Display is in text mode |
| bypass | input | 1 | High disables all wait generation |
| wait_o | output | 1 | Active-high wait request to the CPU |

## Verification
The bench uses the default parameters: a 4000 kHz clock rate and limits of 2000, 8000 and 3000 ns. This gives thresholds of 8, 32 and 12 cycles. These are short enough that every threshold can be hit exactly: a bench issuing back-to-back requests sees 6, 30 and 10 wait cycles, and a chosen number of idle cycles moves a request to just before or just after each limit. With the 12-cycle transfer window shorter than the 32-cycle active spacing, a data write that follows a control write still shows that control writes do not restart the count.

// File: rtl/vdp_pace_pkg.sv
package vdp_pace_pkg;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_CTRL = 2'd2,
        ACC_OTHER = 2'd3
    } acc_kind_t;

    // cycles needed to cover a time in ns at a clock given in kHz, rounded up
    function automatic int ns_to_cyc(input int ns, input int khz);
        longint prod;
        prod = longint'(ns) * longint'(khz);
        return int'((prod + 64'd999999) / 64'd1000000);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/vdp_pace_decode.sv
module vdp_pace_decode
    import vdp_pace_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_ADDR = 1,
    parameter int CTRL_ADDR = 2
) (
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output acc_kind_t         kind
);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    always_comb begin
        if (!io_wr)                kind = ACC_NONE;
        else if (io_addr == DATA_A) kind = ACC_DATA;
        else if (io_addr == CTRL_A) kind = ACC_CTRL;
        else                        kind = ACC_OTHER;
    end
endmodule

// File: rtl/vdp_pace_timer.sv
module vdp_pace_timer #(
    parameter int CNT_MAX = 32,
    localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);

    // count of cycles since the last accepted data write, saturating;
    // reset loads the saturated value so nothing is pending
    always_ff @(posedge clk) begin
        if (rst)             cnt <= TOP;
        else if (restart)    cnt <= CNT_W'(1);
        else if (cnt != TOP) cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/vdp_pace_gate.sv
module vdp_pace_gate
    import vdp_pace_pkg::*;
#(
    parameter int FAST_CYC = 8,
    parameter int SLOW_CYC = 32,
    parameter int XFER_CYC = 12,
    parameter int CNT_W    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_kind_t        kind,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ph_blank,
    input  logic             ph_vblank,
    input  logic             ph_text,
    input  logic             bypass,
    output logic             wait_o,
    output logic             data_done
);
    localparam logic [CNT_W-1:0] FAST_T = CNT_W'(FAST_CYC);
    localparam logic [CNT_W-1:0] SLOW_T = CNT_W'(SLOW_CYC);
    localparam logic [CNT_W-1:0] XFER_T = CNT_W'(XFER_CYC);

    logic             served;
    logic             relaxed;
    logic [CNT_W-1:0] data_t;
    logic             hold;
    logic             accept;

    always_comb begin
        relaxed = ph_blank | ph_vblank | ph_text;
        data_t  = relaxed ? FAST_T : SLOW_T;
        unique case (kind)
            ACC_DATA: hold = (cnt < data_t);
            ACC_CTRL: hold = (cnt < XFER_T);
            default:  hold = 1'b0;
        endcase
        wait_o    = !bypass && !served && hold;
        accept    = (kind != ACC_NONE) && !served && !wait_o;
        data_done = accept && (kind == ACC_DATA);
    end

    // an accepted request is remembered until the strobe drops
    always_ff @(posedge clk) begin
        if (rst)                    served <= 1'b0;
        else if (kind == ACC_NONE)  served <= 1'b0;
        else if (accept)            served <= 1'b1;
    end
endmodule

// File: rtl/vdp_pace.sv
module vdp_pace
    import vdp_pace_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_ADDR = 1,
    parameter int CTRL_ADDR = 2,
    parameter int CLK_KHZ   = 4000,
    parameter int FAST_NS   = 2000,
    parameter int SLOW_NS   = 8000,
    parameter int XFER_NS   = 3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              ph_blank,
    input  logic              ph_vblank,
    input  logic              ph_text,
    input  logic              bypass,
    output logic              wait_o
);
    localparam int FAST_CYC = ns_to_cyc(FAST_NS, CLK_KHZ);
    localparam int SLOW_CYC = ns_to_cyc(SLOW_NS, CLK_KHZ);
    localparam int XFER_CYC = ns_to_cyc(XFER_NS, CLK_KHZ);
    localparam int CNT_MAX  = max3(FAST_CYC, SLOW_CYC, XFER_CYC);
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    acc_kind_t        kind;
    logic [CNT_W-1:0] cnt;
    logic             data_done;

    vdp_pace_decode #(
        .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)
    ) u_decode (
        .io_wr(io_wr), .io_addr(io_addr), .kind(kind)
    );

    vdp_pace_timer #(.CNT_MAX(CNT_MAX)) u_timer (
        .clk(clk), .rst(rst), .restart(data_done), .cnt(cnt)
    );

    vdp_pace_gate #(
        .FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC),
        .XFER_CYC(XFER_CYC), .CNT_W(CNT_W)
    ) u_gate (
        .clk(clk), .rst(rst), .kind(kind), .cnt(cnt),
        .ph_blank(ph_blank), .ph_vblank(ph_vblank), .ph_text(ph_text),
        .bypass(bypass), .wait_o(wait_o), .data_done(data_done)
    );
endmodule

// File: rtl/vdp_pace_chk.sv
module vdp_pace_chk #(
    parameter int ADDR_W    = 8,
    parameter int DATA_ADDR = 1,
    parameter int CTRL_ADDR = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              io_wr,
    input logic [ADDR_W-1:0] io_addr,
    input logic              bypass,
    input logic              wait_o
);
    logic is_paced;
    assign is_paced = (io_addr == ADDR_W'(DATA_ADDR)) || (io_addr == ADDR_W'(CTRL_ADDR));

    assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !wait_o);

    assert_other_port_free_R7: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !is_paced) |-> !wait_o);

    assert_bypass_free_R8: assert property (@(posedge clk) disable iff (rst)
        bypass |-> !wait_o);

    assert_idle_free_R9: assert property (@(posedge clk) disable iff (rst)
        !io_wr |-> !wait_o);

    assert_held_no_rewait_R9: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !wait_o) |=> (!(io_wr && $stable(io_addr)) || !wait_o));
endmodule

bind vdp_pace vdp_pace_chk #(
    .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr),
    .bypass(bypass), .wait_o(wait_o)
);

// File: tb/vdp_pace_bench.sv
module vdp_pace_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_wr = 1'b0;
    logic [7:0] io_addr = 8'd0;
    logic       ph_blank = 1'b0, ph_vblank = 1'b0, ph_text = 1'b0, bypass = 1'b0;
    logic       wait_o;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vdp_pace u_vdp_pace (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr),
        .ph_blank(ph_blank), .ph_vblank(ph_vblank), .ph_text(ph_text),
        .bypass(bypass), .wait_o(wait_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // issue a write after 'gap' idle cycles, keep it 'hold' cycles after
    // acceptance, return the number of wait cycles seen
    task automatic wr(input logic [7:0] a, input int gap, input int hold, output int n);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; #1;
        n = 0;
        while (wait_o && n < 100) begin
            @(negedge clk); #1; n++;
        end
        @(negedge clk);
        repeat (hold) @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic set_phase(input logic b, input logic v, input logic t);
        ph_blank = b; ph_vblank = v; ph_text = t;
    endtask

    task automatic t_reset();
        int n;
        check("R1 wait low after reset", int'(wait_o), 0);
        set_phase(1'b0, 1'b0, 1'b0);
        wr(8'd1, 0, 0, n);
        check("R1 first data write", n, 0);
    endtask

    task automatic t_fast();
        int n;
        set_phase(1'b1, 1'b0, 1'b0);
        wr(8'd1, 40, 0, n); wr(8'd1, 0, 0, n);
        check("R2 blanked spacing", n, 6);
        set_phase(1'b0, 1'b1, 1'b0);
        wr(8'd1, 0, 0, n);
        check("R2 vblank spacing", n, 6);
        set_phase(1'b0, 1'b0, 1'b1);
        wr(8'd1, 0, 0, n);
        check("R2 text spacing", n, 6);
    endtask

    task automatic t_slow();
        int n;
        set_phase(1'b0, 1'b0, 1'b0);
        wr(8'd1, 40, 0, n); wr(8'd1, 0, 0, n);
        check("R3 active spacing", n, 30);
        wr(8'd1, 10, 0, n);
        check("R4 partial gap", n, 20);
        wr(8'd1, 29, 0, n);
        check("R4 one short of limit", n, 1);
        wr(8'd1, 30, 0, n);
        check("R4 gap reaches limit", n, 0);
    endtask

    task automatic t_ctrl();
        int n;
        set_phase(1'b1, 1'b0, 1'b0);
        wr(8'd1, 40, 0, n); wr(8'd2, 0, 0, n);
        check("R5 control after data", n, 10);
        wr(8'd2, 0, 0, n);
        check("R5 second control", n, 0);
        wr(8'd1, 40, 0, n); wr(8'd2, 10, 0, n);
        check("R5 control after window", n, 0);
        // R6: control accepted 12 cycles after data; data 2 later sees 14
        set_phase(1'b0, 1'b0, 1'b0);
        wr(8'd1, 40, 0, n); wr(8'd2, 0, 0, n); wr(8'd1, 0, 0, n);
        check("R6 control keeps count", n, 18);
    endtask

    task automatic t_other();
        int n;
        set_phase(1'b0, 1'b0, 1'b0);
        wr(8'd1, 40, 0, n); wr(8'd3, 0, 0, n);
        check("R7 other port", n, 0);
        wr(8'd0, 0, 0, n);
        check("R7 port zero", n, 0);
        // R6: the other writes did not restart; accepted at +2,+4; next at +6
        wr(8'd1, 0, 0, n);
        check("R6 other write keeps count", n, 26);
    endtask

    task automatic t_bypass();
        int n;
        set_phase(1'b0, 1'b0, 1'b0);
        bypass = 1'b1;
        wr(8'd1, 0, 0, n); wr(8'd1, 0, 0, n);
        check("R8 bypass data", n, 0);
        wr(8'd2, 0, 0, n);
        check("R8 bypass control", n, 0);
        bypass = 1'b0;
    endtask

    task automatic t_hold();
        int n;
        set_phase(1'b1, 1'b0, 1'b0);
        wr(8'd1, 40, 5, n);
        check("R9 held strobe no wait", int'(wait_o), 0);
        wr(8'd1, 0, 0, n);
        check("R9 held strobe counted once", n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_fast();
        t_slow();
        t_ctrl();
        t_other();
        t_bypass();
        t_hold();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run complete)");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule